// File: doc/BRIEF.md
# Event-Triggered Delayed One-Shot Pulse Generator

This block turns a single qualifying edge on an asynchronous input into one output pulse that starts a programmed delay later and lasts a programmed width. It is the one-shot mode of a general-purpose timer. When that mode is not selected, the block stays idle and leaves the timer to its capture and counting duties. The edge polarity is chosen by a control input. The delay and width are counted in prescaled ticks, and the prescaler divides the clock by the programmed value plus one.

A pulse passes through four phases that can be read back: waiting, delay, start-shot and shot. The input crosses a synchronizer, so the effective delay is the programmed tick count plus a fixed three-cycle synchronization time. The start-shot phase lasts one tick and loads the width counter. The output is high only during the shot phase. When the shot ends, the block returns to waiting and raises a one-cycle done flag. That flag becomes the interrupt when the interrupt is unmasked.

Top module: `evt_delay_shot`

## Requirements
- R1: During and after reset, `phase` reads 0, and `shot_out`, `done` and `irq` are low.
- R2: The phase encoding is 0 = waiting, 1 = delay, 2 = start-shot, 3 = shot. A pulse visits these phases in the order 0, 1, 2, 3, 0.
- R3: If the input makes a qualifying change between clock edges, `phase` reads 1 after the third rising clock edge. This three-cycle figure is the synchronization time. The delay phase then lasts `delay_ticks` ticks.
- R4: The start-shot phase lasts exactly one tick.
- R5: `shot_out` is high exactly while `phase` reads 3. The shot phase lasts `width_ticks` ticks.
- R6: One tick is `prescale`+1 clock cycles. The tick divider restarts when an event is accepted, so phase lengths are exact multiples of `prescale`+1 counted from entry into the delay phase.
- R7: With `fall_sel`=0 only a low-to-high input change triggers. With `fall_sel`=1 only a high-to-low change triggers.
- R8: Input edges that arrive while `phase` is not 0 are ignored and cause no second pulse.
- R9: `done` is high for one cycle on the clock edge where the shot phase returns to waiting. `irq` equals `done` when `irq_unmask`=1 and stays low when `irq_unmask`=0.
- R10: If `run_en` is low at a clock edge, `phase` reads 0 and `shot_out` is low after that edge. Counting happens only while `run_en` is high.
- R11: With `oneshot_sel`=0, edges start nothing and `phase` stays 0.
- R12: A `delay_ticks` or `width_ticks` value of 0 gives a phase of one tick. An all-ones value gives the full count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Global enable for counting |
| oneshot_sel | input | 1 | 1 selects one-shot mode |
| fall_sel | input | 1 | Trigger polarity: 1 falling, 0 rising |
| irq_unmask | input | 1 | 1 lets `done` through to `irq` |
| prescale | input | CNT_W | Tick divider; tick = clk / (value+1) |
| delay_ticks | input | CNT_W | Delay phase length in ticks |
| width_ticks | input | CNT_W | Shot phase length in ticks |
| trig_in | input | 1 | Asynchronous trigger input |
| phase | output | 2 | Current phase code |
| shot_out | output | 1 | Pulse output |
| done | output | 1 | One-cycle end-of-shot flag |
| irq | output | 1 | Masked end-of-shot interrupt |

## Verification
The bench builds the block with `CNT_W`=8 and the default two-flop synchronizer. The narrow counter lets an all-ones delay of 255 ticks run in a few hundred cycles, so the full-count boundary is reached alongside the zero-value minimum. Every scenario compares the phase, output, done and interrupt values cycle by cycle against a timeline derived from the tick length. This covers a divide-by-one prescaler and a divide-by-three prescaler, both polarities, retrigger noise, the mask, mode-off and mid-shot disable.

// File: rtl/evs_pkg.sv
// Package: shared phase type for the delayed one-shot generator.
// Assumes: the 2-bit encoding is observed by software and must not change.
package evs_pkg;

    typedef enum logic [1:0] {
        PH_WAIT  = 2'd0,
        PH_DELAY = 2'd1,
        PH_START = 2'd2,
        PH_SHOT  = 2'd3
    } phase_e;

endpackage

// File: rtl/evs_edge_sync.sv
// Module: evs_edge_sync
// Synchronizes an asynchronous input through SYNC_FLOPS flops, then
// compares against one more flop to find a change of the selected polarity.
// Assumes: trig_in pulses are at least one clock wide. Latency from an
// input change to a registered consumer of hit is SYNC_FLOPS+1 edges.
module evs_edge_sync #(
    parameter int SYNC_FLOPS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fall_sel,
    input  logic trig_in,
    output logic hit
);

    logic [SYNC_FLOPS-1:0] chain_q;
    logic                  prev_q;

    // Stage 0 captures the raw input.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= trig_in;
    end

    generate
        for (genvar g = 1; g < SYNC_FLOPS; g++) begin : g_stage
            // Later stages shift the sampled level along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[g] <= 1'b0;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    endgenerate

    // Holds the previous synchronized level for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[SYNC_FLOPS-1];
    end

    // Flags a change of the selected polarity.
    always_comb begin
        if (fall_sel) hit = prev_q & ~chain_q[SYNC_FLOPS-1];
        else          hit = ~prev_q & chain_q[SYNC_FLOPS-1];
    end

endmodule

// File: rtl/evs_prescaler.sv
// Module: evs_prescaler
// Emits a one-cycle tick every prescale+1 cycles while run_en is high.
// Assumes: restart realigns the divider so the next tick comes
// prescale+1 cycles later. The divider is held at zero while disabled.
module evs_prescaler #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             restart,
    input  logic [CNT_W-1:0] prescale,
    output logic             tick
);

    logic [CNT_W-1:0] div_q;

    // Tick when the divider has reached the programmed value.
    assign tick = run_en && (div_q >= prescale);

    // Advances the divider, wrapping on tick and clearing on restart.
    always_ff @(posedge clk) begin
        if (!rst_n)                 div_q <= '0;
        else if (!run_en || restart) div_q <= '0;
        else if (tick)              div_q <= '0;
        else                        div_q <= div_q + 1'b1;
    end

endmodule

// File: rtl/evs_phase_fsm.sv
// Module: evs_phase_fsm
// Phase sequencer with a shared down-counter: wait -> delay -> start ->
// shot -> wait. Each phase advances only on a tick.
// Assumes: hit is already synchronized. A zero length is treated as one
// tick. Leaving enable or mode forces the waiting phase.
module evs_phase_fsm
    import evs_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             oneshot_sel,
    input  logic             hit,
    input  logic             tick,
    input  logic [CNT_W-1:0] delay_ticks,
    input  logic [CNT_W-1:0] width_ticks,
    output logic             accept,
    output phase_e           phase,
    output logic             shot_q,
    output logic             done_q
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    phase_e           nxt;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_n;
    logic             fin;

    // Converts a programmed length into its counter preload.
    function automatic logic [CNT_W-1:0] preload(input logic [CNT_W-1:0] v);
        return (v == '0) ? '0 : (v - ONE);
    endfunction

    // Next-phase and counter decisions.
    always_comb begin
        nxt    = phase;
        cnt_n  = cnt_q;
        accept = 1'b0;
        fin    = 1'b0;
        if (!run_en || !oneshot_sel) begin
            nxt   = PH_WAIT;
            cnt_n = '0;
        end else begin
            unique case (phase)
                PH_WAIT: begin
                    if (hit) begin
                        nxt    = PH_DELAY;
                        cnt_n  = preload(delay_ticks);
                        accept = 1'b1;
                    end
                end
                PH_DELAY: begin
                    if (tick) begin
                        if (cnt_q == '0) nxt = PH_START;
                        else             cnt_n = cnt_q - ONE;
                    end
                end
                PH_START: begin
                    if (tick) begin
                        nxt   = PH_SHOT;
                        cnt_n = preload(width_ticks);
                    end
                end
                PH_SHOT: begin
                    if (tick) begin
                        if (cnt_q == '0) begin
                            nxt = PH_WAIT;
                            fin = 1'b1;
                        end else begin
                            cnt_n = cnt_q - ONE;
                        end
                    end
                end
                default: nxt = PH_WAIT;
            endcase
        end
    end

    // Phase, counter, output and done registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_WAIT;
            cnt_q  <= '0;
            shot_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            phase  <= nxt;
            cnt_q  <= cnt_n;
            shot_q <= (nxt == PH_SHOT);
            done_q <= fin;
        end
    end

endmodule

// File: rtl/evt_delay_shot.sv
// Module: evt_delay_shot (top)
// Delayed one-shot pulse generator: edge synchronizer, tick divider and
// phase sequencer. irq is done gated by the mask input.
// Assumes: all control inputs are synchronous to clk. trig_in is async.
module evt_delay_shot
    import evs_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int SYNC_FLOPS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             oneshot_sel,
    input  logic             fall_sel,
    input  logic             irq_unmask,
    input  logic [CNT_W-1:0] prescale,
    input  logic [CNT_W-1:0] delay_ticks,
    input  logic [CNT_W-1:0] width_ticks,
    input  logic             trig_in,
    output logic [1:0]       phase,
    output logic             shot_out,
    output logic             done,
    output logic             irq
);

    logic   hit_w;
    logic   tick_w;
    logic   accept_w;
    phase_e phase_w;

    evs_edge_sync #(.SYNC_FLOPS(SYNC_FLOPS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .fall_sel (fall_sel),
        .trig_in  (trig_in),
        .hit      (hit_w)
    );

    evs_prescaler #(.CNT_W(CNT_W)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .restart  (accept_w),
        .prescale (prescale),
        .tick     (tick_w)
    );

    evs_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_en      (run_en),
        .oneshot_sel (oneshot_sel),
        .hit         (hit_w),
        .tick        (tick_w),
        .delay_ticks (delay_ticks),
        .width_ticks (width_ticks),
        .accept      (accept_w),
        .phase       (phase_w),
        .shot_q      (shot_out),
        .done_q      (done)
    );

    assign phase = phase_w;
    assign irq   = done & irq_unmask;

endmodule

// File: rtl/evs_checker.sv
// Module: evs_checker
// Concurrent properties for evt_delay_shot, attached by bind below.
module evs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       run_en,
    input logic       oneshot_sel,
    input logic       irq_unmask,
    input logic       tick,
    input logic [1:0] phase,
    input logic       shot_out,
    input logic       done,
    input logic       irq
);

    p_wait_succ_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd0) |=> (phase == 2'd0 || phase == 2'd1));
    p_delay_succ_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd1) |=> (phase != 2'd3));
    p_shot_succ_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd3) |=> (phase == 2'd3 || phase == 2'd0));
    p_start_one_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd2 && tick && run_en && oneshot_sel) |=> (phase == 2'd3));
    p_out_in_shot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        shot_out |-> (phase == 2'd3));
    p_done_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (phase == 2'd0 && $past(phase) == 2'd3));
    p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_unmask |-> !irq);
    p_disable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (phase == 2'd0 && !shot_out));
    p_mode_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !oneshot_sel |=> (phase == 2'd0));

endmodule

bind evt_delay_shot evs_checker u_evs_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_en      (run_en),
    .oneshot_sel (oneshot_sel),
    .irq_unmask  (irq_unmask),
    .tick        (tick_w),
    .phase       (phase),
    .shot_out    (shot_out),
    .done        (done),
    .irq         (irq)
);

// File: tb/evt_delay_shot_tb_top.sv
// Directed bench for evt_delay_shot; each scenario task checks itself.
module evt_delay_shot_tb_top;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         run_en = 1'b0;
    logic         oneshot_sel = 1'b0;
    logic         fall_sel = 1'b0;
    logic         irq_unmask = 1'b0;
    logic [W-1:0] prescale = '0;
    logic [W-1:0] delay_ticks = '0;
    logic [W-1:0] width_ticks = '0;
    logic         trig_in = 1'b0;
    logic [1:0]   phase;
    logic         shot_out;
    logic         done;
    logic         irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    evt_delay_shot #(.CNT_W(W), .SYNC_FLOPS(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .oneshot_sel(oneshot_sel),
        .fall_sel(fall_sel), .irq_unmask(irq_unmask), .prescale(prescale),
        .delay_ticks(delay_ticks), .width_ticks(width_ticks), .trig_in(trig_in),
        .phase(phase), .shot_out(shot_out), .done(done), .irq(irq)
    );

    task automatic expect_eq(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Waits for n rising edges, then returns at the following falling edge.
    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Runs one shot and compares every cycle against the expected timeline.
    task automatic run_shot(input string req, input int d, input int w, input int p,
                            input bit fall, input bit unmask, input bit noisy);
        int t, dl, wl, k_end;
        bit idle;
        t  = p + 1;
        dl = ((d == 0) ? 1 : d) * t;
        wl = ((w == 0) ? 1 : w) * t;
        k_end = 3 + dl + t + wl;
        idle = fall;
        fall_sel = fall; irq_unmask = unmask;
        prescale = W'(p); delay_ticks = W'(d); width_ticks = W'(w);
        oneshot_sel = 1'b1; run_en = 1'b1;
        trig_in = idle;
        step(5);
        trig_in = ~idle;
        for (int k = 1; k <= k_end + 2; k++) begin
            int ep;
            @(negedge clk);
            if (k < 3)                 ep = 0;
            else if (k < 3 + dl)       ep = 1;
            else if (k < 3 + dl + t)   ep = 2;
            else if (k < k_end)        ep = 3;
            else                       ep = 0;
            expect_eq(req, "phase", int'(phase), ep);
            expect_eq(req, "shot_out", int'(shot_out), int'(ep == 3));
            expect_eq(req, "done", int'(done), int'(k == k_end));
            expect_eq(req, "irq", int'(irq), int'(k == k_end && unmask));
            if (noisy && k >= 4 && k <= k_end - 4 && (k % 2 == 0)) trig_in = ~trig_in;
            else if (noisy && k == k_end - 3) trig_in = idle;
            else if (!noisy && k == 2) trig_in = idle;
        end
        trig_in = idle;
        step(6);
        expect_eq(req, "phase stays idle", int'(phase), 0);
    endtask

    task automatic t_reset();
        step(3);
        expect_eq("R1", "phase", int'(phase), 0);
        expect_eq("R1", "shot_out", int'(shot_out), 0);
        expect_eq("R1", "done", int'(done), 0);
        expect_eq("R1", "irq", int'(irq), 0);
        rst_n = 1'b1;
        step(2);
        expect_eq("R1", "phase after release", int'(phase), 0);
        expect_eq("R1", "shot_out after release", int'(shot_out), 0);
    endtask

    // R10: dropping run_en in the shot phase returns to waiting next edge.
    task automatic t_disable();
        fall_sel = 0; irq_unmask = 1; prescale = '0;
        delay_ticks = W'(2); width_ticks = W'(20);
        run_en = 1; oneshot_sel = 1; trig_in = 0;
        step(5);
        trig_in = 1;
        step(7);
        expect_eq("R10", "in shot before disable", int'(phase), 3);
        expect_eq("R10", "output high before disable", int'(shot_out), 1);
        run_en = 0;
        step(1);
        expect_eq("R10", "phase after disable", int'(phase), 0);
        expect_eq("R10", "shot_out after disable", int'(shot_out), 0);
        trig_in = 0;
        run_en = 1;
        step(4);
        expect_eq("R10", "no resume after re-enable", int'(phase), 0);
        expect_eq("R10", "output low after re-enable", int'(shot_out), 0);
    endtask

    // R11: in capture/timer mode an edge does not start a shot.
    task automatic t_mode_off();
        int bad = 0;
        fall_sel = 0; run_en = 1; oneshot_sel = 0;
        delay_ticks = W'(1); width_ticks = W'(1); prescale = '0;
        trig_in = 0;
        step(4);
        trig_in = 1;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (phase != 2'd0 || shot_out) bad++;
        end
        expect_eq("R11", "non-idle cycles with mode off", bad, 0);
        trig_in = 0;
        step(4);
        oneshot_sel = 1;
        step(2);
        expect_eq("R11", "idle after mode on", int'(phase), 0);
    endtask

    // R7: the wrong-polarity change starts nothing.
    task automatic t_wrong_edge();
        int bad = 0;
        fall_sel = 1; run_en = 1; oneshot_sel = 1;
        delay_ticks = W'(1); width_ticks = W'(1); prescale = '0;
        trig_in = 0;
        step(5);
        trig_in = 1;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (phase != 2'd0) bad++;
        end
        expect_eq("R7", "rising edge with falling polarity", bad, 0);
    endtask

    initial begin
        t_reset();
        run_shot("R2 R3 R5", 3, 4, 0, 1'b0, 1'b1, 1'b0);
        run_shot("R6", 2, 3, 2, 1'b0, 1'b1, 1'b0);
        run_shot("R7", 4, 2, 0, 1'b1, 1'b1, 1'b0);
        t_wrong_edge();
        run_shot("R8", 6, 6, 0, 1'b0, 1'b1, 1'b1);
        run_shot("R9", 1, 2, 0, 1'b0, 1'b0, 1'b0);
        run_shot("R4", 1, 1, 3, 1'b0, 1'b1, 1'b0);
        run_shot("R12", 0, 0, 0, 1'b0, 1'b1, 1'b0);
        run_shot("R12", 0, 0, 1, 1'b1, 1'b1, 1'b0);
        run_shot("R12", 255, 2, 0, 1'b0, 1'b1, 1'b0);
        t_disable();
        t_mode_off();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule